// File: doc/BRIEF.md
# Set-Associative Byte Cache Controller

This block is a small read/write cache placed between a processor-side request port and a slower block-wide backing memory. Each request carries a byte address, a read/write flag and one write byte. The cache answers with a one-cycle response pulse that carries the read byte and a flag telling whether the request was served from a resident line. Misses, refills and evictions are handled by a small sequencer that moves whole blocks over the memory port. During that time the request port is held not-ready.

The geometry is fixed at elaboration. The parameters set the address width, the set-index width, the block-offset width and the number of lines per set (1 for direct-mapped, 2 for two-way with one least-recently-used bit per set). A static parameter selects one of two write-policy pairings. The first pairs write-back with write-allocate. The second pairs write-through with no-write-allocate.

Top module: `sa_cache`

## Requirements
- R1: A request address splits, from most to least significant, into a tag, a set index of SET_W bits and a byte offset of OFF_W bits. A request hits only when a valid line in the indexed set holds the same tag. rsp_hit is 1 for a hit and 0 for a miss.
- R2: A read hit returns the byte at the offset within the cached block on rsp_rdata, with rsp_hit = 1, and makes no memory transaction. The byte at offset k of a block occupies bits [8k+7:8k] of every block bus.
- R3: With one line per set, a tag mismatch evicts the resident line and refills the set with the requested block. The byte reads 0, 1, 7, 8, 0 with 4-bit addresses, 2-byte blocks and 4 sets give miss, hit, miss, miss, miss.
- R4: With two lines per set, a miss first fills an invalid line (line 0 before line 1). When both lines are valid, the miss replaces the least recently used line. The byte reads 0, 1, 7, 8, 0 with 4-bit addresses, 2-byte blocks and 2 sets give miss, hit, miss, miss, hit.
- R5: In write-back mode, a write hit changes only the cached byte and marks the line dirty. The only memory writes are full-block evictions, with every bit of mem_be set.
- R6: In write-back mode, a write miss first refills the block from memory and then merges the write byte into it. The line is left dirty and the response reports a miss.
- R7: Before the refill of a new block, an evicted dirty line is written back as a whole block to the memory block address formed from its own tag and set. Clean lines are dropped without a memory write.
- R8: In write-through mode, every write becomes one memory write with exactly one mem_be bit set (bit k for offset k). A write hit also updates the cached byte. A write miss leaves the cache unchanged.
- R9: req_ready is high only while the controller is idle. It falls in the cycle after a request is accepted and stays low until the response. rsp_valid lasts exactly one cycle. For a write, rsp_rdata is 0.
- R10: Reset clears every valid bit, every dirty bit and every recency bit. After reset the first access to any address misses, and both ports are idle.
- R11: A memory request holds mem_valid, mem_we and mem_baddr unchanged until the cycle in which mem_ready completes it. A read completes with the block on mem_rblock in that same cycle.
- R12: The recency bit of a set is updated on every hit and on every refill, so that it points at the line of the set that was not just used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; a request is taken at this edge |
| req_addr | input | ADDR_W | Byte address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | 1 when served from a resident line |
| rsp_rdata | output | 8 | Read byte (0 for writes) |
| mem_valid | output | 1 | Memory transaction request |
| mem_ready | input | 1 | Memory completes the transaction this cycle |
| mem_we | output | 1 | 1 = write block bytes, 0 = read block |
| mem_baddr | output | ADDR_W-OFF_W | Block address (tag and set) |
| mem_be | output | 2**OFF_W | Byte enables for a write |
| mem_wblock | output | 8*2**OFF_W | Write block |
| mem_rblock | input | 8*2**OFF_W | Read block, valid with mem_ready |

## Verification
The bench builds four copies, all with 4-bit addresses and 2-byte blocks. They are direct-mapped with four sets and two-way with two sets, each under both write policies. These tiny geometries make the two fixed read traces exact. They also put conflict misses, dirty evictions and recency flips only a few accesses apart. A behavioural model shadows each copy's line state and backing memory, predicting hit flags, read bytes, memory write counts and memory contents for a long mixed read/write stream.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WBACK,
    ST_FILL,
    ST_WTHRU
  } cache_st_e;

  // Two-line victim choice: empty line 0, then empty line 1, then the LRU line.
  function automatic logic choose_victim(input logic [1:0] vld, input logic lru_way);
    if (!vld[0]) return 1'b0;
    if (!vld[1]) return 1'b1;
    return lru_way;
  endfunction

endpackage

// File: rtl/sa_cache_way.sv
module sa_cache_way #(
  parameter int SET_W = 2,
  parameter int TAG_W = 4,
  parameter int OFF_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SET_W-1:0]         set_i,
  input  logic [TAG_W-1:0]         tag_i,
  input  logic                     fill_en,
  input  logic [(8<<OFF_W)-1:0]    fill_blk,
  input  logic                     fill_dirty,
  input  logic                     wr_en,
  input  logic [OFF_W-1:0]         wr_off,
  input  logic [7:0]               wr_byte,
  input  logic                     wr_dirty,
  output logic                     line_vld,
  output logic                     line_dirty,
  output logic [TAG_W-1:0]         line_tag,
  output logic [(8<<OFF_W)-1:0]    line_blk,
  output logic                     line_hit
);
  localparam int NSETS = 1 << SET_W;
  localparam int BLK_W = 8 << OFF_W;

  logic [NSETS-1:0] vld_q;
  logic [NSETS-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [NSETS];
  logic [BLK_W-1:0] blk_q [NSETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      vld_q[set_i]   <= 1'b1;
      dirty_q[set_i] <= fill_dirty;
    end else if (wr_en && wr_dirty) begin
      dirty_q[set_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[set_i] <= tag_i;
      blk_q[set_i] <= fill_blk;
    end else if (wr_en) begin
      blk_q[set_i][{wr_off, 3'b000} +: 8] <= wr_byte;
    end
  end

  assign line_vld   = vld_q[set_i];
  assign line_dirty = dirty_q[set_i];
  assign line_tag   = tag_q[set_i];
  assign line_blk   = blk_q[set_i];
  assign line_hit   = line_vld && (line_tag == tag_i);

endmodule

// File: rtl/sa_cache_lru.sv
module sa_cache_lru #(
  parameter int SET_W = 2,
  parameter int WAYS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_i,
  input  logic             touch_en,
  input  logic             touch_way,
  output logic             lru_way
);
  localparam int NSETS = 1 << SET_W;

  generate
    if (WAYS > 1) begin : g_two
      logic [NSETS-1:0] lru_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        lru_q <= '0;
        else if (touch_en) lru_q[set_i] <= ~touch_way;
      end
      assign lru_way = lru_q[set_i];
    end else begin : g_one
      logic lru_unused;
      assign lru_unused = ^{clk, rst_n, set_i, touch_en, touch_way};
      assign lru_way    = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/sa_cache.sv
module sa_cache
  import sa_cache_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int SET_W      = 4,
  parameter int OFF_W      = 2,
  parameter int WAYS       = 2,
  parameter int WRITE_BACK = 1,
  localparam int BLK_B     = 1 << OFF_W,
  localparam int BLK_W     = 8 * BLK_B,
  localparam int BADDR_W   = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_we,
  input  logic [7:0]         req_wdata,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [7:0]         rsp_rdata,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic               mem_we,
  output logic [BADDR_W-1:0] mem_baddr,
  output logic [BLK_B-1:0]   mem_be,
  output logic [BLK_W-1:0]   mem_wblock,
  input  logic [BLK_W-1:0]   mem_rblock
);
  localparam int  TAG_W   = ADDR_W - SET_W - OFF_W;
  localparam bit  WT_MODE = (WRITE_BACK == 0);

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: SET_W];
  endfunction
  function automatic logic [OFF_W-1:0] off_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction
  function automatic logic [7:0] byte_at(input logic [BLK_W-1:0] blk, input logic [OFF_W-1:0] off);
    return blk[{off, 3'b000} +: 8];
  endfunction
  function automatic logic [BLK_W-1:0] put_byte(input logic [BLK_W-1:0] blk,
                                                input logic [OFF_W-1:0] off,
                                                input logic [7:0] b);
    logic [BLK_W-1:0] r;
    r = blk;
    r[{off, 3'b000} +: 8] = b;
    return r;
  endfunction

  cache_st_e         state;
  logic [ADDR_W-1:0] r_addr;
  logic              r_we;
  logic [7:0]        r_wdata;
  logic              r_way;
  logic              r_hit;

  logic [TAG_W-1:0] r_tag;
  logic [SET_W-1:0] r_set;
  logic [OFF_W-1:0] r_off;
  assign r_tag = tag_of(r_addr);
  assign r_set = set_of(r_addr);
  assign r_off = off_of(r_addr);

  logic [WAYS-1:0]  way_vld, way_dirty, way_hit;
  logic [TAG_W-1:0] way_tag [WAYS];
  logic [BLK_W-1:0] way_blk [WAYS];

  logic             any_hit, hit_way, victim, vic_dirty, lru_pick;
  logic [TAG_W-1:0] sel_tag;
  logic [BLK_W-1:0] sel_blk, hit_blk;

  // Named events used by the controller and observed by the checker.
  logic look_hit, look_miss, hit_read_evt, byte_wr, fill_fire, wb_fire, touch_en, touch_way;
  logic [BLK_W-1:0] fill_blk;

  assign any_hit      = |way_hit;
  assign look_hit     = (state == ST_LOOK) && any_hit;
  assign look_miss    = (state == ST_LOOK) && !any_hit;
  assign hit_read_evt = look_hit && !r_we;
  assign byte_wr      = look_hit && r_we;
  assign fill_fire    = (state == ST_FILL) && mem_ready;
  assign wb_fire      = (state == ST_WBACK) && mem_ready;
  assign touch_en     = look_hit || fill_fire;
  assign touch_way    = look_hit ? hit_way : r_way;
  assign fill_blk     = r_we ? put_byte(mem_rblock, r_off, r_wdata) : mem_rblock;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      sa_cache_way #(.SET_W(SET_W), .TAG_W(TAG_W), .OFF_W(OFF_W)) way_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (r_set),
        .tag_i      (r_tag),
        .fill_en    (fill_fire && (WAYS == 1 || r_way == 1'(w))),
        .fill_blk   (fill_blk),
        .fill_dirty (r_we),
        .wr_en      (byte_wr && way_hit[w]),
        .wr_off     (r_off),
        .wr_byte    (r_wdata),
        .wr_dirty   (!WT_MODE),
        .line_vld   (way_vld[w]),
        .line_dirty (way_dirty[w]),
        .line_tag   (way_tag[w]),
        .line_blk   (way_blk[w]),
        .line_hit   (way_hit[w])
      );
    end

    if (WAYS > 1) begin : g_sel2
      assign hit_way   = way_hit[1];
      assign hit_blk   = hit_way ? way_blk[1] : way_blk[0];
      assign victim    = choose_victim(way_vld[1:0], lru_pick);
      assign vic_dirty = victim ? (way_vld[1] && way_dirty[1]) : (way_vld[0] && way_dirty[0]);
      assign sel_tag   = r_way ? way_tag[1] : way_tag[0];
      assign sel_blk   = r_way ? way_blk[1] : way_blk[0];
    end else begin : g_sel1
      assign hit_way   = 1'b0;
      assign hit_blk   = way_blk[0];
      assign victim    = 1'b0;
      assign vic_dirty = way_vld[0] && way_dirty[0];
      assign sel_tag   = way_tag[0];
      assign sel_blk   = way_blk[0];
    end
  endgenerate

  sa_cache_lru #(.SET_W(SET_W), .WAYS(WAYS)) lru_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (r_set),
    .touch_en  (touch_en),
    .touch_way (touch_way),
    .lru_way   (lru_pick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      r_addr    <= '0;
      r_we      <= 1'b0;
      r_wdata   <= '0;
      r_way     <= 1'b0;
      r_hit     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          r_addr  <= req_addr;
          r_we    <= req_we;
          r_wdata <= req_wdata;
          state   <= ST_LOOK;
        end
        ST_LOOK: begin
          r_hit <= any_hit;
          if (look_hit) r_way <= hit_way;
          else          r_way <= victim;
          if (WT_MODE && r_we) begin
            state <= ST_WTHRU;
          end else if (look_hit) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b1;
            rsp_rdata <= r_we ? 8'h00 : byte_at(hit_blk, r_off);
            state     <= ST_IDLE;
          end else if (look_miss && vic_dirty) begin
            state <= ST_WBACK;
          end else begin
            state <= ST_FILL;
          end
        end
        ST_WBACK: if (mem_ready) state <= ST_FILL;
        ST_FILL: if (mem_ready) begin
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b0;
          rsp_rdata <= r_we ? 8'h00 : byte_at(mem_rblock, r_off);
          state     <= ST_IDLE;
        end
        ST_WTHRU: if (mem_ready) begin
          rsp_valid <= 1'b1;
          rsp_hit   <= r_hit;
          rsp_rdata <= 8'h00;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == ST_IDLE);
  assign mem_valid  = (state == ST_WBACK) || (state == ST_FILL) || (state == ST_WTHRU);
  assign mem_we     = (state != ST_FILL);
  assign mem_baddr  = (state == ST_WBACK) ? {sel_tag, r_set} : r_addr[ADDR_W-1:OFF_W];
  assign mem_be     = (state == ST_WTHRU) ? (BLK_B'(1) << r_off) : '1;
  assign mem_wblock = (state == ST_WBACK) ? sel_blk : {BLK_B{r_wdata}};

endmodule

// File: rtl/sa_cache_chk.sv
module sa_cache_chk #(
  parameter int BLK_B      = 4,
  parameter int BADDR_W    = 10,
  parameter int WRITE_BACK = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               mem_valid,
  input logic               mem_ready,
  input logic               mem_we,
  input logic [BADDR_W-1:0] mem_baddr,
  input logic [BLK_B-1:0]   mem_be,
  input logic               hit_read_evt,
  input logic               wb_fire
);

  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !rsp_valid));

  p_hit_no_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_read_evt |=> (rsp_valid && !mem_valid));

  p_wb_then_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |=> (mem_valid && !mem_we));

  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_baddr) && $stable(mem_we)));

  p_wb_full_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (WRITE_BACK != 0 && mem_valid && mem_we) |-> (&mem_be));

  p_wt_one_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (WRITE_BACK == 0 && mem_valid && mem_we) |-> ($countones(mem_be) == 1));

endmodule

bind sa_cache sa_cache_chk #(
  .BLK_B      (BLK_B),
  .BADDR_W    (BADDR_W),
  .WRITE_BACK (WRITE_BACK)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .mem_valid    (mem_valid),
  .mem_ready    (mem_ready),
  .mem_we       (mem_we),
  .mem_baddr    (mem_baddr),
  .mem_be       (mem_be),
  .hit_read_evt (hit_read_evt),
  .wb_fire      (wb_fire)
);

// File: tb/sa_cache_harness.sv
module sa_cache_harness #(
  parameter int SET_W      = 2,
  parameter int WAYS       = 1,
  parameter int WRITE_BACK = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic done,
  output int   n_chk,
  output int   n_fail
);
  localparam int ADDR_W = 4;
  localparam int OFF_W  = 1;
  localparam int NSETS  = 1 << SET_W;
  localparam int MEM_N  = 16;

  logic       req_valid, req_ready, req_we, rsp_valid, rsp_hit;
  logic [3:0] req_addr;
  logic [7:0] req_wdata, rsp_rdata;
  logic       mem_valid, mem_ready, mem_we;
  logic [2:0] mem_baddr;
  logic [1:0] mem_be;
  logic [15:0] mem_wblock, mem_rblock;

  sa_cache #(.ADDR_W(ADDR_W), .SET_W(SET_W), .OFF_W(OFF_W), .WAYS(WAYS),
             .WRITE_BACK(WRITE_BACK)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_baddr(mem_baddr), .mem_be(mem_be), .mem_wblock(mem_wblock),
    .mem_rblock(mem_rblock)
  );

  // Backing memory: completes each transaction three cycles after it appears.
  logic [7:0] phys [MEM_N];
  int lat_cnt;
  int wr_seen;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ready <= 1'b0;
      lat_cnt   <= 0;
      wr_seen   <= 0;
      for (int i = 0; i < MEM_N; i++) phys[i] <= 8'((i * 37 + 11) & 255);
    end else if (mem_valid && mem_ready) begin
      if (mem_we) begin
        for (int b = 0; b < 2; b++)
          if (mem_be[b]) phys[int'(mem_baddr) * 2 + b] <= mem_wblock[b*8 +: 8];
        wr_seen <= wr_seen + 1;
      end
      mem_ready <= 1'b0;
      lat_cnt   <= 0;
    end else if (mem_valid) begin
      if (lat_cnt == 2) mem_ready <= 1'b1;
      else              lat_cnt   <= lat_cnt + 1;
    end
  end

  assign mem_rblock = {phys[int'(mem_baddr) * 2 + 1], phys[int'(mem_baddr) * 2]};

  // Behavioural reference: line state per set and line, plus expected memory.
  int         m_vld   [NSETS][WAYS];
  int         m_dirty [NSETS][WAYS];
  int         m_tag   [NSETS][WAYS];
  int         m_lru   [NSETS];
  logic [7:0] m_dat   [NSETS][WAYS][2];
  logic [7:0] ref_mem [MEM_N];
  int         wr_exp;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %m %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_access(input int a, input int we, input logic [7:0] wd,
                              output int hit, output logic [7:0] rd);
    int s, t, o, hw, v, base;
    s = (a >> 1) % NSETS;
    t = a >> (1 + SET_W);
    o = a % 2;
    hw = -1;
    for (int w = 0; w < WAYS; w++)
      if (m_vld[s][w] != 0 && m_tag[s][w] == t) hw = w;
    hit = (hw >= 0) ? 1 : 0;
    rd = 8'h00;
    if (we != 0 && WRITE_BACK == 0) begin
      ref_mem[a] = wd;
      wr_exp++;
      if (hit != 0) begin
        m_dat[s][hw][o] = wd;
        if (WAYS > 1) m_lru[s] = 1 - hw;
      end
    end else if (hit != 0) begin
      if (we != 0) begin
        m_dat[s][hw][o] = wd;
        m_dirty[s][hw] = 1;
      end else begin
        rd = m_dat[s][hw][o];
      end
      if (WAYS > 1) m_lru[s] = 1 - hw;
    end else begin
      v = 0;
      if (WAYS > 1) begin
        if (m_vld[s][0] == 0)      v = 0;
        else if (m_vld[s][1] == 0) v = 1;
        else                       v = m_lru[s];
      end
      if (m_vld[s][v] != 0 && m_dirty[s][v] != 0) begin
        base = (m_tag[s][v] * NSETS + s) * 2;
        ref_mem[base]     = m_dat[s][v][0];
        ref_mem[base + 1] = m_dat[s][v][1];
        wr_exp++;
      end
      m_vld[s][v]    = 1;
      m_tag[s][v]    = t;
      m_dirty[s][v]  = 0;
      m_dat[s][v][0] = ref_mem[a & 14];
      m_dat[s][v][1] = ref_mem[a | 1];
      if (we != 0) begin
        m_dat[s][v][o] = wd;
        m_dirty[s][v]  = 1;
      end else begin
        rd = m_dat[s][v][o];
      end
      if (WAYS > 1) m_lru[s] = 1 - v;
    end
  endtask

  task automatic access(input int a, input int we, input logic [7:0] wd,
                        input int fixed_hit, input string fixed_tag);
    int mh;
    logic [7:0] mrd;
    int cyc;
    bit mem_ok;
    model_access(a, we, wd, mh, mrd);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready while idle", int'(req_ready), 1);
    req_valid = 1'b1;
    req_addr  = 4'(a);
    req_we    = (we != 0);
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!rsp_valid && cyc < 40) begin
      chk(req_ready == 1'b0, "R9 ready low while busy", int'(req_ready), 0);
      @(negedge clk);
      cyc++;
    end
    chk(rsp_valid == 1'b1, "R9 response arrives", int'(rsp_valid), 1);
    if (WAYS > 1) chk(int'(rsp_hit) == mh, "R1 R12 hit flag", int'(rsp_hit), mh);
    else          chk(int'(rsp_hit) == mh, "R1 hit flag", int'(rsp_hit), mh);
    if (fixed_hit >= 0) chk(int'(rsp_hit) == fixed_hit, fixed_tag, int'(rsp_hit), fixed_hit);
    if (we != 0) chk(rsp_rdata == 8'h00, "R9 write rdata zero", int'(rsp_rdata), 0);
    else if (mh != 0) chk(rsp_rdata == mrd, "R2 read hit byte", int'(rsp_rdata), int'(mrd));
    else chk(rsp_rdata == mrd, "R6 refill byte", int'(rsp_rdata), int'(mrd));
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 response one cycle", int'(rsp_valid), 0);
    if (WRITE_BACK != 0) chk(wr_seen == wr_exp, "R5 R7 memory write count", wr_seen, wr_exp);
    else                 chk(wr_seen == wr_exp, "R8 memory write count", wr_seen, wr_exp);
    mem_ok = 1'b1;
    for (int i = 0; i < MEM_N; i++) if (phys[i] !== ref_mem[i]) mem_ok = 1'b0;
    if (WRITE_BACK != 0) chk(mem_ok, "R7 memory contents", int'(mem_ok), 1);
    else                 chk(mem_ok, "R8 memory contents", int'(mem_ok), 1);
  endtask

  // Memory request stability, compared every clock.
  logic prev_wait;
  logic [2:0] prev_baddr;
  logic prev_we;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_wait = 1'b0;
    end else begin
      if (prev_wait)
        chk(mem_valid && mem_baddr == prev_baddr && mem_we == prev_we,
            "R11 memory request held", int'(mem_baddr), int'(prev_baddr));
      prev_wait  = mem_valid && !mem_ready;
      prev_baddr = mem_baddr;
      prev_we    = mem_we;
    end
  end

  initial begin
    int tr_a [5];
    int tr_dm [5];
    int tr_2w [5];
    int x;
    done      = 1'b0;
    n_chk     = 0;
    n_fail    = 0;
    req_valid = 1'b0;
    req_addr  = '0;
    req_we    = 1'b0;
    req_wdata = '0;
    wr_exp    = 0;
    for (int i = 0; i < MEM_N; i++) ref_mem[i] = 8'((i * 37 + 11) & 255);
    for (int s = 0; s < NSETS; s++) begin
      m_lru[s] = 0;
      for (int w = 0; w < WAYS; w++) begin
        m_vld[s][w] = 0; m_dirty[s][w] = 0; m_tag[s][w] = 0;
      end
    end
    wait (rst_n === 1'b1);
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_valid == 1'b0,
        "R10 idle after reset", int'({req_ready, rsp_valid, mem_valid}), 4);

    // Fixed read traces.
    tr_a  = '{0, 1, 7, 8, 0};
    tr_dm = '{0, 1, 0, 0, 0};
    tr_2w = '{0, 1, 0, 0, 1};
    for (int i = 0; i < 5; i++) begin
      if (i == 0)        access(tr_a[i], 0, 8'h00, 0, "R10 first access misses");
      else if (WAYS > 1) access(tr_a[i], 0, 8'h00, tr_2w[i], "R4 two-way trace");
      else               access(tr_a[i], 0, 8'h00, tr_dm[i], "R3 direct trace");
    end

    // Directed writes, conflicts and dirty evictions.
    access(0, 1, 8'hA5, -1, "");
    access(0, 0, 8'h00, -1, "");
    access(9, 1, 8'h3C, -1, "");
    access(9, 0, 8'h00, -1, "");
    access(4, 0, 8'h00, -1, "");
    access(12, 0, 8'h00, -1, "");
    access(0, 0, 8'h00, -1, "");
    access(8, 0, 8'h00, -1, "");
    access(6, 1, 8'h77, -1, "");
    access(14, 1, 8'hE1, -1, "");
    access(6, 0, 8'h00, -1, "");
    access(14, 0, 8'h00, -1, "");
    access(2, 0, 8'h00, -1, "");
    access(6, 0, 8'h00, -1, "");

    // Mixed pseudo-random stream.
    x = 32'h1234_5678 + SET_W * 17 + WRITE_BACK * 5;
    for (int k = 0; k < 80; k++) begin
      x = x * 1103515245 + 12345;
      access((x >> 8) & 15, (x >> 13) & 1, 8'((x >> 16) & 255), -1, "");
    end
    done = 1'b1;
  end

endmodule

// File: tb/sa_cache_tb_top.sv
module sa_cache_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic d0, d1, d2, d3;
  int   c0, c1, c2, c3, f0, f1, f2, f3;

  sa_cache_harness #(.SET_W(2), .WAYS(1), .WRITE_BACK(1)) h_dm_wb (
    .clk(clk), .rst_n(rst_n), .done(d0), .n_chk(c0), .n_fail(f0));
  sa_cache_harness #(.SET_W(1), .WAYS(2), .WRITE_BACK(1)) h_2w_wb (
    .clk(clk), .rst_n(rst_n), .done(d1), .n_chk(c1), .n_fail(f1));
  sa_cache_harness #(.SET_W(1), .WAYS(2), .WRITE_BACK(0)) h_2w_wt (
    .clk(clk), .rst_n(rst_n), .done(d2), .n_chk(c2), .n_fail(f2));
  sa_cache_harness #(.SET_W(2), .WAYS(1), .WRITE_BACK(0)) h_dm_wt (
    .clk(clk), .rst_n(rst_n), .done(d3), .n_chk(c3), .n_fail(f3));

  initial begin
    int cyc;
    int total_chk;
    int total_fail;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!(d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1 && d3 === 1'b1) && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    total_chk  = c0 + c1 + c2 + c3 + 1;
    total_fail = f0 + f1 + f2 + f3;
    if (cyc >= 100000) begin
      total_fail++;
      $display("FAIL watchdog R9 actual %0d expected below %0d", cyc, 100000);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", total_chk, total_fail);
    $finish;
  end
endmodule